// File: doc/BRIEF.md
# Row-Scan Frame Timing Generator

This block derives the complete rolling-shutter timing of a pixel matrix from one fast readout clock. A cycle counter divides each row into a fixed number of readout-clock cycles. A row counter steps through the matrix rows, and a frame counter counts finished frames. Because row length and sequencer rate are fixed divisions of the readout clock, the integration time follows the clock frequency: with the default 640 rows of 160 cycles, one frame lasts 102,400 clock periods, which is 640 us at 160 MHz.

Three one-cycle strobes come out of the block. A sequencer tick drives the in-pixel sequencer at one tenth of the clock, giving 16 ticks per row. A row-latch strobe hands the finished row to the serializer in the last cycle of the row. A start-of-frame marker lets several chips on a shared ladder be compared for alignment, and the frame counter is exposed next to it. An external resync request restarts every counter at once, so that a chip that has drifted can be brought back into step with its neighbours. A run input freezes the whole timing when it is low.

Top module: `row_scan_timer`

## Requirements
- R1: While run is high, the in-row cycle position advances once per clock and wraps from 159 to 0; the row index increments exactly once every 160 advancing cycles, so consecutive row-latch strobes are 160 cycles apart under continuous run.
- R2: The row index counts 0 to 639 and wraps to 0; at that wrap the 16-bit frame counter increases by one, and consecutive start-of-frame markers are 102,400 cycles apart under continuous run.
- R3: seq_tick is a one-cycle pulse in the cycles whose in-row position is 9, 19, ..., 159, giving exactly 16 pulses per row.
- R4: row_latch is a one-cycle pulse that is high only in the cycle whose in-row position is 159.
- R5: frame_start is a one-cycle pulse, high only in the first cycle of row 0 that follows either a wrap from row 639 or a resync request; row_idx is 0 whenever it is high.
- R6: A resync request clears the row index, the in-row position and the frame counter on the next clock edge and raises frame_start for that cycle; it takes priority over run.
- R7: While run is low and resync is low, row_idx and frame_cnt hold their values and row_latch and seq_tick stay low.
- R8: After reset, row_idx and frame_cnt are 0 and all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast readout clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Advance the timing when high, freeze when low |
| resync | input | 1 | Restart all counters on the next edge |
| row_idx | output | 10 | Current row being read |
| row_latch | output | 1 | One-cycle strobe in the last cycle of a row |
| seq_tick | output | 1 | One-cycle sequencer enable, every tenth cycle |
| frame_start | output | 1 | One-cycle marker in the first cycle of a frame |
| frame_cnt | output | 16 | Count of completed frames |

## Verification
Every output is a register, so each result is due one clock edge after the cycle in which the inputs that cause it were applied. The bench drives run and resync on the falling edge, steps a reference model on the rising edge from those same inputs, and compares all outputs at the next falling edge, so the expected value and the design output refer to the same edge. The period checks (160 cycles per row, 16 ticks per row, 102,400 cycles per frame) count falling edges between strobes during an uninterrupted run.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  // Control pair shared by every counter stage.
  typedef struct packed {
    logic clr;  // restart to zero
    logic adv;  // take one step
  } step_ctl_t;
endpackage

// File: rtl/rs_cycle_ctr.sv
module rs_cycle_ctr
  import row_scan_pkg::*;
#(
  parameter int CYC_PER_ROW = 160,
  parameter int SEQ_DIV     = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  step_ctl_t ctl,
  output logic      last_o,
  output logic      latch_o,
  output logic      tick_o
);
  localparam int CW = $clog2(CYC_PER_ROW);
  localparam int SW = $clog2(SEQ_DIV);

  logic [CW-1:0] cyc_q;
  logic [SW-1:0] sub_q;

  assign last_o = (cyc_q == CW'(CYC_PER_ROW - 1));

  always_ff @(posedge clk) begin
    if (rst || ctl.clr) begin
      cyc_q   <= '0;
      sub_q   <= '0;
      latch_o <= 1'b0;
      tick_o  <= 1'b0;
    end else if (ctl.adv) begin
      cyc_q   <= last_o ? '0 : cyc_q + 1'b1;
      sub_q   <= (sub_q == SW'(SEQ_DIV - 1)) ? '0 : sub_q + 1'b1;
      latch_o <= (cyc_q == CW'(CYC_PER_ROW - 2));
      tick_o  <= (sub_q == SW'(SEQ_DIV - 2));
    end else begin
      latch_o <= 1'b0;
      tick_o  <= 1'b0;
    end
  end

  p_cyc_range_r1: assert property (@(posedge clk) disable iff (rst)
    cyc_q < CW'(CYC_PER_ROW));
  p_latch_last_r4: assert property (@(posedge clk) disable iff (rst)
    latch_o |-> last_o);
  p_latch_single_r4: assert property (@(posedge clk) disable iff (rst)
    latch_o |=> !latch_o);
endmodule

// File: rtl/rs_row_ctr.sv
module rs_row_ctr
  import row_scan_pkg::*;
#(
  parameter int ROWS = 640
) (
  input  logic                    clk,
  input  logic                    rst,
  input  step_ctl_t               ctl,
  output logic [$clog2(ROWS)-1:0] row_o,
  output logic                    last_o
);
  localparam int RW = $clog2(ROWS);

  assign last_o = (row_o == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst || ctl.clr)  row_o <= '0;
    else if (ctl.adv)    row_o <= last_o ? '0 : row_o + 1'b1;
  end

  p_row_range_r2: assert property (@(posedge clk) disable iff (rst)
    row_o < RW'(ROWS));
endmodule

// File: rtl/rs_frame_ctr.sv
module rs_frame_ctr
  import row_scan_pkg::*;
#(
  parameter int FCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  step_ctl_t         ctl,
  output logic [FCNT_W-1:0] cnt_o,
  output logic              sof_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      sof_o <= 1'b0;
    end else begin
      sof_o <= ctl.clr || ctl.adv;
      if (ctl.clr)      cnt_o <= '0;
      else if (ctl.adv) cnt_o <= cnt_o + 1'b1;
    end
  end

  p_sof_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (sof_o && !ctl.clr) |=> !sof_o);
endmodule

// File: rtl/row_scan_timer.sv
module row_scan_timer
  import row_scan_pkg::*;
#(
  parameter int ROWS        = 640,
  parameter int CYC_PER_ROW = 160,
  parameter int SEQ_DIV     = 10,
  parameter int FCNT_W      = 16,
  localparam int RW         = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              resync,
  output logic [RW-1:0]     row_idx,
  output logic              row_latch,
  output logic              seq_tick,
  output logic              frame_start,
  output logic [FCNT_W-1:0] frame_cnt
);
  logic      step, cyc_last, row_last;
  step_ctl_t cyc_ctl, row_ctl, frm_ctl;

  assign step        = run && !resync;
  assign cyc_ctl.clr = resync;
  assign cyc_ctl.adv = step;
  assign row_ctl.clr = resync;
  assign row_ctl.adv = step && cyc_last;
  assign frm_ctl.clr = resync;
  assign frm_ctl.adv = step && cyc_last && row_last;

  rs_cycle_ctr #(.CYC_PER_ROW(CYC_PER_ROW), .SEQ_DIV(SEQ_DIV)) u_cyc (
    .clk(clk), .rst(rst), .ctl(cyc_ctl),
    .last_o(cyc_last), .latch_o(row_latch), .tick_o(seq_tick));

  rs_row_ctr #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst(rst), .ctl(row_ctl),
    .row_o(row_idx), .last_o(row_last));

  rs_frame_ctr #(.FCNT_W(FCNT_W)) u_frm (
    .clk(clk), .rst(rst), .ctl(frm_ctl),
    .cnt_o(frame_cnt), .sof_o(frame_start));

  p_resync_clear_r6: assert property (@(posedge clk) disable iff (rst)
    resync |=> (row_idx == '0 && frame_cnt == '0 && frame_start));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!run && !resync) |=> ($stable(row_idx) && $stable(frame_cnt) && !row_latch && !seq_tick));
  p_sof_row0_r5: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> row_idx == '0);
  p_latch_tick_r3: assert property (@(posedge clk) disable iff (rst)
    row_latch |-> seq_tick);
endmodule

// File: tb/sim_row_scan_timer.sv
`timescale 1ns/1ps
module sim_row_scan_timer;
  localparam int ROWS = 640, CYC = 160, SDIV = 10;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, resync = 1'b0;
  logic [9:0]  row_idx;
  logic [15:0] frame_cnt;
  logic row_latch, seq_tick, frame_start;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  row_scan_timer u0 (.clk(clk), .rst(rst), .run(run), .resync(resync),
    .row_idx(row_idx), .row_latch(row_latch), .seq_tick(seq_tick),
    .frame_start(frame_start), .frame_cnt(frame_cnt));

  // Reference model of the requirements, stepped on the rising edge.
  int m_pos = 0, m_row = 0, m_frm = 0;
  bit e_lat = 0, e_seq = 0, e_sof = 0;

  function automatic bit is_tick_pos(int p);
    return (p % SDIV) == SDIV - 1;  // R3: positions 9, 19, ..., 159
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_row = 0; m_frm = 0; e_lat = 0; e_seq = 0; e_sof = 0;
    end else if (resync) begin
      m_pos = 0; m_row = 0; m_frm = 0; e_lat = 0; e_seq = 0; e_sof = 1;
    end else if (run) begin
      e_sof = 0;
      if (m_pos == CYC - 1) begin
        m_pos = 0;
        if (m_row == ROWS - 1) begin
          m_row = 0; m_frm = (m_frm + 1) & 16'hFFFF; e_sof = 1;
        end else m_row = m_row + 1;
      end else m_pos = m_pos + 1;
      e_lat = (m_pos == CYC - 1);
      e_seq = is_tick_pos(m_pos);
    end else begin
      e_lat = 0; e_seq = 0; e_sof = 0;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(string ctx);
    chk(row_idx == 10'(m_row), {ctx, " R1/R2 row_idx"}, row_idx, m_row);
    chk(frame_cnt == 16'(m_frm), {ctx, " R2 frame_cnt"}, frame_cnt, m_frm);
    chk(row_latch == e_lat, {ctx, " R4 row_latch"}, row_latch, e_lat);
    chk(seq_tick == e_seq, {ctx, " R3 seq_tick"}, seq_tick, e_seq);
    chk(frame_start == e_sof, {ctx, " R5 frame_start"}, frame_start, e_sof);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int gap_lat, gap_sof, ticks, prev_frm;
    bit seen_lat, seen_sof;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(row_idx == 0 && frame_cnt == 0, "R8 counters after reset", row_idx, 0);
    chk(!row_latch && !seq_tick && !frame_start, "R8 strobes after reset",
        {row_latch, seq_tick, frame_start}, 0);
    rst = 1'b0;

    // Random phase: run toggling, occasional resync (R6, R7).
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      compare_all("rand");
      run    = ($urandom_range(0, 99) < 80);
      resync = ($urandom_range(0, 999) < 3);
    end

    // Directed: resync together with run (R6 priority).
    @(negedge clk); run = 1'b1; resync = 1'b1;
    @(negedge clk); compare_all("resync");
    chk(frame_start && row_idx == 0 && frame_cnt == 0, "R6 resync clears",
        {frame_start, row_idx}, 10'h400);
    resync = 1'b0;

    // Directed: stall mid-row, outputs must hold (R7).
    repeat (37) begin @(negedge clk); compare_all("pre-stall"); end
    run = 1'b0;
    repeat (50) begin
      @(negedge clk);
      compare_all("stall");
      chk(!row_latch && !seq_tick, "R7 no strobes while stopped", row_latch, 0);
    end
    @(negedge clk); resync = 1'b1; run = 1'b1;
    @(negedge clk); compare_all("resync2"); resync = 1'b0;

    // Continuous run over more than one frame: periods (R1, R2, R3).
    gap_lat = 0; gap_sof = 0; ticks = 0; seen_lat = 0; seen_sof = 1;
    prev_frm = 0;
    for (int i = 0; i < ROWS * CYC + 500; i++) begin
      @(negedge clk);
      compare_all("cont");
      gap_lat++; gap_sof++;
      if (seq_tick) ticks++;
      if (row_latch) begin
        if (seen_lat) begin
          chk(gap_lat == CYC, "R1 row period", gap_lat, CYC);
          chk(ticks == CYC / SDIV, "R3 ticks per row", ticks, CYC / SDIV);
        end
        seen_lat = 1; gap_lat = 0; ticks = 0;
      end
      if (frame_start) begin
        chk(row_idx == 0, "R5 marker in row 0", row_idx, 0);
        if (seen_sof) begin
          chk(gap_sof == ROWS * CYC, "R2 frame period", gap_sof, ROWS * CYC);
          chk(int'(frame_cnt) == prev_frm + 1, "R2 frame count step",
              frame_cnt, prev_frm + 1);
        end
        prev_frm = frame_cnt; gap_sof = 0;
      end
    end
    done = 1;
    finish_run();
  end
endmodule